// File: doc/BRIEF.md
# Self-Correcting Decimal Counter Chain

This block is a synchronous decimal counter made of a chain of four-bit digits, four of them by default, so it spans 0000 to 9999. When a steady 100 Hz tick drives the enable, the chain reads elapsed time from 00.00 to 99.99 seconds. Each digit's next state comes from fixed two-level equations built from its own four flip-flops. There is no compare-against-ten-and-zero step. As a result, the six codes that are not decimal digits (10 to 15) still have defined successors, and they return to the valid range after at most two counts.

Each digit moves forward only when the enable is high and every less significant digit holds 9. The digit's carry then becomes the enable of the next digit up, and the carry out of the top digit is brought out so that chains can be stacked. A synchronous clear and a parallel load share the clock with the counting path. The parallel load can place any code into any digit, including the unused codes. An asynchronous active-low reset zeroes everything.

Top module: `decade_chain`

## Requirements
- R1: While `rst_n` is low, `bcd` is all zeros and `carry` is low, whatever the clock is doing.
- R2: A digit whose advance condition holds steps 0,1,2,...,8,9 and then wraps from 9 to 0. Digit k occupies `bcd[4k+3:4k]`, plain binary, with bit 0 the least significant.
- R3: When a digit holding an unused code advances, it moves along these pairs: 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15, and 15 to 2.
- R4: When `en` is low and neither `clr` nor `load` is high, `bcd` keeps its value across the clock edge.
- R5: Digit k advances on an edge only when `en` is high and all digits below k hold 9. A digit with an unused code never passes a carry upward. `carry` is high exactly when `en` is high and every digit holds 9.
- R6: `clr` high sets `bcd` to zero on the next edge and overrides both `load` and `en`.
- R7: `load` high, with `clr` low, copies `load_val` into `bcd` on the next edge and overrides `en`.
- R8: Starting from zero with `en` held high, the whole chain counts in decimal through 9999 and then wraps back to 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to zero |
| load | input | 1 | Synchronous parallel load |
| load_val | input | 4*DIGITS | Value copied in by `load` |
| en | input | 1 | Count enable (tick) for the lowest digit |
| bcd | output | 4*DIGITS | Counter value, one nibble per digit, least significant digit in the low nibble |
| carry | output | 1 | High when `en` is high and all digits are 9 |

## Verification
All sixteen codes are loaded into the lowest digit in turn, and the bench follows each one until it is back in range. This separates correct equations from a counter that merely resets on overflow, and it confirms the exact path each unused code takes. A full sweep of 10000 ticks from zero catches faults in the carry ripple, such as a mid-chain digit that advances early or a wrong top carry. Loads of unused codes into the second digit confirm that such a digit advances only on a real carry and never passes one upward. Hold and priority patterns then set enable, load and clear against one another.

// File: rtl/decade_chain.sv
module decade_chain #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] bcd,
  output logic         carry
);

  logic [DIGITS:0] ripple;
  logic [W-1:0]    nxt;

  assign ripple[0] = en;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    logic [3:0] q;
    logic [3:0] step;
    assign q = bcd[4*k +: 4];
    assign step[0] = ~q[0];
    assign step[1] = q[1] ^ (q[0] & ~q[3]);
    assign step[2] = q[2] ^ (q[0] & q[1]);
    assign step[3] = q[3] ^ ((q[0] & q[3]) | (q[0] & q[1] & q[2]));
    assign nxt[4*k +: 4] = ripple[k] ? step : q;
    assign ripple[k+1] = ripple[k] & (q == 4'd9);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bcd <= '0;
    else if (clr)   bcd <= '0;
    else if (load)  bcd <= load_val;
    else            bcd <= nxt;
  end

  assign carry = ripple[DIGITS];

endmodule

module decade_chain_chk #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         load,
  input logic         en,
  input logic [W-1:0] bcd,
  input logic         carry
);

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> (bcd == '0 && !carry));

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !load && bcd[3:0] < 4'd9) |=> bcd[3:0] == $past(bcd[3:0]) + 4'd1);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !load && bcd[3:0] == 4'd9) |=> bcd[3:0] == 4'd0);

  p_unused_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !load && bcd[3:0] > 4'd9 && bcd[0]) |=> bcd[3:0] < 4'd10);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr && !load) |=> $stable(bcd));

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (en && bcd == {DIGITS{4'd9}}));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> bcd == '0);

endmodule

bind decade_chain decade_chain_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .en(en), .bcd(bcd), .carry(carry)
);

// File: tb/decade_chain_test.sv
`timescale 1ns/1ps
module decade_chain_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic        en = 1'b0;
  logic [15:0] bcd;
  logic        carry;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  decade_chain #(.DIGITS(4)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_val(load_val),
    .en(en), .bcd(bcd), .carry(carry)
  );

  function automatic int next_code(int v);
    if (v < 9) return v + 1;
    if (v == 9) return 0;
    if (v % 2 == 0) return v + 1;
    return 17 - v;
  endfunction

  function automatic logic [15:0] to_bcd(int n);
    logic [15:0] r;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic c, logic l, logic [15:0] lv, logic e);
    @(negedge clk);
    clr = c; load = l; load_val = lv; en = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", bcd, 0);
    check("R1 reset carry", carry, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 / R2: every code of the lowest digit, followed back into 0..9
    for (int v = 0; v < 16; v++) begin
      int cur;
      int hi;
      cyc(0, 1, 16'(v), 0);
      check("R7 load code", bcd, v);
      cur = v;
      hi = 0;
      for (int s = 0; s < 3; s++) begin
        if (cur == 9) hi++;
        cur = next_code(cur);
        cyc(0, 0, 0, 1);
        check(v > 9 ? "R3 unused path" : "R2 step", bcd, 32'(hi * 16 + cur));
        if (cur < 10) break;
      end
    end

    // R5: unused code in digit 1 only moves on a real carry
    cyc(0, 1, 16'h00A9, 0);
    cyc(0, 0, 0, 1);
    check("R5 digit1 10->11 on carry", bcd, 32'h00B0);
    cyc(0, 1, 16'h00A5, 0);
    cyc(0, 0, 0, 1);
    check("R5 digit1 unchanged without carry", bcd, 32'h00A6);
    cyc(0, 1, 16'h09F9, 0);
    cyc(0, 0, 0, 1);
    check("R5 digit1 15->2 no carry up", bcd, 32'h0920);

    // R4 hold
    cyc(0, 1, 16'h1234, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0);
      check("R4 hold", bcd, 32'h1234);
    end

    // R7 load overrides enable, R6 clear overrides load and enable
    cyc(0, 1, 16'h0555, 1);
    check("R7 load over enable", bcd, 32'h0555);
    cyc(1, 1, 16'h7777, 1);
    check("R6 clear priority", bcd, 0);

    // R5 carry near the top, R8 wrap
    cyc(0, 1, 16'h9998, 0);
    @(negedge clk);
    clr = 0; load = 0; en = 1;
    #1;
    check("R5 carry low at 9998", carry, 0);
    @(posedge clk); #1;
    check("R8 reach 9999", bcd, 32'h9999);
    @(negedge clk); #1;
    check("R5 carry high at 9999", carry, 1);
    en = 0; #1;
    check("R5 carry needs enable", carry, 0);
    en = 1;
    @(posedge clk); #1;
    check("R8 wrap to 0000", bcd, 0);

    // R8 full sweep from zero
    cyc(1, 0, 0, 0);
    for (int n = 0; n < 10000; n++) begin
      @(negedge clk);
      clr = 0; load = 0; en = 1;
      #1;
      if (n == 9999) check("R5 carry at top of sweep", carry, 1);
      @(posedge clk); #1;
      check("R8 sweep", bcd, to_bcd((n + 1) % 10000));
    end

    // R1 asynchronous reset between edges
    cyc(0, 1, 16'h4321, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", bcd, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule